// File: doc/BRIEF.md
# Load/Store Address and Extend Unit

This unit sits between a pipeline's operand read and its data memory port. For each memory request it forms the effective address from a base register value and an offset, and decides whether the base register is updated and to what value. It also produces the byte enables and the lane-replicated store data for the access. On the return side it selects the addressed byte or halfword from the memory word and sign- or zero-extends it to a full load result.

The offset can be absent, a 12-bit unsigned immediate, or a register value shifted left by 0 to 31 places. It is either added to the base or subtracted from it. In pre-indexed mode the access uses the computed address, and that address may optionally be written back to the base register. In post-indexed mode the access uses the base unchanged, and the base register always receives base plus or minus offset. Accesses are little-endian. An access that is not aligned to its size raises a fault and is not issued.

A request is captured on a rising clock edge and its results appear on the outputs for one cycle after that edge. The memory is expected to present the read word on `rdata_i` in that same cycle, and the extended load result follows from it without a register in between.

Top module: `lsu_agu`

## Requirements
- R1: While `rst_ni` is low, and at the first edge after it rises with no request, `mem_req_o`, `mem_we_o`, `be_o`, `wdata_o`, `addr_o`, `wb_en_o`, `wb_val_o`, `align_fault_o` and `ld_data_o` are all zero.
- R2: The offset selected by `off_sel_i` is zero when it is 2'b00, the 12-bit `imm_i` zero-extended when it is 2'b01, and `off_reg_i` shifted logically left by `shamt_i` (0..31) when it is 2'b10 or 2'b11.
- R3: When `sub_i` is 1 the offset is subtracted from `base_i`, otherwise it is added. Both wrap modulo 2^32.
- R4: With `pre_i`=1 the access address is base±offset. `wb_en_o` equals `wb_i`, and `wb_val_o` equals that same address.
- R5: With `pre_i`=0 the access address is `base_i`. `wb_en_o` is 1 and `wb_val_o` is base±offset.
- R6: `size_i` encodes 2'b00 byte, 2'b01 halfword, and 2'b10 or 2'b11 word. A halfword access with address bit 0 set, or a word access with address bits [1:0] nonzero, sets `align_fault_o`. It also forces `mem_req_o`, `mem_we_o`, `be_o`, `wdata_o` and `wb_en_o` to zero. `addr_o` still shows the faulting address.
- R7: Bit k of `be_o` enables byte lane k (bits 8k+7..8k). A byte access enables lane addr[1:0], a halfword access enables lanes {1,0} when addr[1]=0 and lanes {3,2} otherwise, and a word access enables all four. `be_o` is zero when no access is issued.
- R8: On a store (`is_load_i`=0), `mem_we_o` is 1. `wdata_o` carries the low byte replicated to all four lanes for a byte store, the low halfword replicated twice for a halfword store, and `st_data_i` unchanged for a word store. `wdata_o` is zero for loads, faults and idle cycles.
- R9: On an issued load, `ld_data_o` is byte lane addr[1:0] of `rdata_i` for a byte access, or bits [31:16] of `rdata_i` when addr[1]=1 and bits [15:0] otherwise for a halfword access. The value is sign-extended when `signed_i`=1 and zero-extended otherwise. A word load passes `rdata_i` through unchanged. `ld_data_o` is zero in any cycle without an issued load.
- R10: Results appear exactly one cycle after `req_i` is sampled high. After an edge with `req_i` low, `mem_req_o`, `wb_en_o` and `align_fault_o` are 0, while `addr_o` and `wb_val_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Memory request valid this cycle |
| is_load_i | input | 1 | 1 for load, 0 for store |
| base_i | input | 32 | Base register value |
| off_sel_i | input | 2 | Offset source: none, immediate, shifted register |
| imm_i | input | 12 | Unsigned immediate offset |
| off_reg_i | input | 32 | Register offset value |
| shamt_i | input | 5 | Left shift amount for the register offset |
| sub_i | input | 1 | Subtract offset from base |
| pre_i | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_i | input | 1 | Write back in pre-indexed mode |
| size_i | input | 2 | Access size |
| signed_i | input | 1 | Sign-extend byte and halfword loads |
| st_data_i | input | 32 | Store data from register |
| rdata_i | input | 32 | Memory read word, in the cycle after the request |
| mem_req_o | output | 1 | Access issued |
| mem_we_o | output | 1 | Access is a write |
| addr_o | output | 32 | Access address |
| be_o | output | 4 | Byte lane enables |
| wdata_o | output | 32 | Lane-replicated store data |
| wb_en_o | output | 1 | Base register write enable |
| wb_val_o | output | 32 | Value for the base register |
| align_fault_o | output | 1 | Misaligned access, suppressed |
| ld_data_o | output | 32 | Extended load result |

## Verification
On every cycle, the assertions check the following. A fault never issues an access or a write-back. Issued byte enables always form a legal byte, aligned-halfword or word pattern. A pre-indexed write-back always carries the access address. A post-indexed access always uses the previous cycle's base and always writes back. An idle cycle issues nothing and reports no fault. The load result is held at zero outside issued loads. Only the bench's scenarios can show the arithmetic itself. That covers the immediate, the shift by 0 and by 31, subtraction wrapping below zero, and the exact lane chosen for each address. It also covers the sign of each extended value and the replication pattern of store data, which the bench compares against its own model of every output on every clock.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRSV = 2'b11
  } lsu_size_e;

  typedef enum logic [1:0] {
    OFS_NONE = 2'b00,
    OFS_IMM  = 2'b01,
    OFS_REG  = 2'b10,
    OFS_REGB = 2'b11
  } lsu_ofs_e;
endpackage

// File: rtl/lsu_offset.sv
module lsu_offset
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12,
  parameter int SHW   = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  base_i,
  input  lsu_ofs_e         sel_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  reg_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic             sub_i,
  output logic [XLEN-1:0]  ea_o
);
  logic [XLEN-1:0] ofs;

  always_comb begin
    unique case (sel_i)
      OFS_NONE: ofs = '0;
      OFS_IMM:  ofs = {{(XLEN-IMM_W){1'b0}}, imm_i};
      default:  ofs = reg_i << shamt_i;
    endcase
    ea_o = sub_i ? (base_i - ofs) : (base_i + ofs);
  end
endmodule

// File: rtl/lsu_lane.sv
module lsu_lane
  import lsu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NL   = XLEN / 8,
  parameter int LW   = $clog2(NL)
) (
  input  logic [LW-1:0]   lsb_i,
  input  lsu_size_e       size_i,
  input  logic [XLEN-1:0] data_i,
  output logic [NL-1:0]   be_o,
  output logic [XLEN-1:0] rep_o,
  output logic            mis_o
);
  logic is_byte, is_half;
  assign is_byte = (size_i == SZ_BYTE);
  assign is_half = (size_i == SZ_HALF);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam logic [LW-1:0] LI = LW'(i);
    assign be_o[i] = is_byte ? (lsb_i == LI)
                   : is_half ? (lsb_i[LW-1:1] == LI[LW-1:1])
                   : 1'b1;
  end

  always_comb begin
    if (is_byte)      rep_o = {NL{data_i[7:0]}};
    else if (is_half) rep_o = {(NL/2){data_i[15:0]}};
    else              rep_o = data_i;
    if (is_byte)      mis_o = 1'b0;
    else if (is_half) mis_o = lsb_i[0];
    else              mis_o = (lsb_i != '0);
  end
endmodule

// File: rtl/lsu_extend.sv
module lsu_extend
  import lsu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NL   = XLEN / 8,
  parameter int LW   = $clog2(NL)
) (
  input  logic [XLEN-1:0] rdata_i,
  input  logic [LW-1:0]   lsb_i,
  input  lsu_size_e       size_i,
  input  logic            sgn_i,
  output logic [XLEN-1:0] data_o
);
  logic [7:0]  b;
  logic [15:0] h;

  assign b = rdata_i[{lsb_i, 3'b000} +: 8];
  assign h = rdata_i[{lsb_i[LW-1:1], 4'b0000} +: 16];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(XLEN-8){sgn_i & b[7]}}, b};
      SZ_HALF: data_o = {{(XLEN-16){sgn_i & h[15]}}, h};
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              is_load_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [1:0]        off_sel_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   off_reg_i,
  input  logic [$clog2(XLEN)-1:0] shamt_i,
  input  logic              sub_i,
  input  logic              pre_i,
  input  logic              wb_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic [XLEN-1:0]   st_data_i,
  input  logic [XLEN-1:0]   rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   addr_o,
  output logic [XLEN/8-1:0] be_o,
  output logic [XLEN-1:0]   wdata_o,
  output logic              wb_en_o,
  output logic [XLEN-1:0]   wb_val_o,
  output logic              align_fault_o,
  output logic [XLEN-1:0]   ld_data_o
);
  localparam int NL  = XLEN / 8;
  localparam int LW  = $clog2(NL);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] ea, acc_addr, rep;
  logic [NL-1:0]   be_c;
  logic            mis, go;
  lsu_size_e       size_c, size_q;
  logic            sgn_q;
  logic [XLEN-1:0] ext;

  assign size_c = lsu_size_e'(size_i);

  lsu_offset #(.XLEN(XLEN), .IMM_W(IMM_W), .SHW(SHW)) i_ofs (
    .base_i  (base_i),
    .sel_i   (lsu_ofs_e'(off_sel_i)),
    .imm_i   (imm_i),
    .reg_i   (off_reg_i),
    .shamt_i (shamt_i),
    .sub_i   (sub_i),
    .ea_o    (ea)
  );

  assign acc_addr = pre_i ? ea : base_i;

  lsu_lane #(.XLEN(XLEN), .NL(NL), .LW(LW)) i_lane (
    .lsb_i  (acc_addr[LW-1:0]),
    .size_i (size_c),
    .data_i (st_data_i),
    .be_o   (be_c),
    .rep_o  (rep),
    .mis_o  (mis)
  );

  assign go = req_i & ~mis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o     <= 1'b0;
      mem_we_o      <= 1'b0;
      addr_o        <= '0;
      be_o          <= '0;
      wdata_o       <= '0;
      wb_en_o       <= 1'b0;
      wb_val_o      <= '0;
      align_fault_o <= 1'b0;
      size_q        <= SZ_BYTE;
      sgn_q         <= 1'b0;
    end else begin
      mem_req_o     <= go;
      mem_we_o      <= go & ~is_load_i;
      be_o          <= go ? be_c : '0;
      wdata_o       <= (go & ~is_load_i) ? rep : '0;
      wb_en_o       <= go & (~pre_i | wb_i);
      align_fault_o <= req_i & mis;
      if (req_i) begin
        addr_o   <= acc_addr;
        wb_val_o <= ea;
        size_q   <= size_c;
        sgn_q    <= signed_i;
      end
    end
  end

  lsu_extend #(.XLEN(XLEN), .NL(NL), .LW(LW)) i_ext (
    .rdata_i (rdata_i),
    .lsb_i   (addr_o[LW-1:0]),
    .size_i  (size_q),
    .sgn_i   (sgn_q),
    .data_o  (ext)
  );

  assign ld_data_o = (mem_req_o & ~mem_we_o) ? ext : '0;
endmodule

// File: rtl/lsu_agu_chk.sv
module lsu_agu_chk #(
  parameter int XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              pre_i,
  input logic [XLEN-1:0]   base_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [XLEN-1:0]   addr_o,
  input logic [XLEN/8-1:0] be_o,
  input logic              wb_en_o,
  input logic [XLEN-1:0]   wb_val_o,
  input logic              align_fault_o,
  input logic [XLEN-1:0]   ld_data_o
);
  AST_FAULT_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |-> (!mem_req_o && !wb_en_o && be_o == '0)); // R6

  AST_BE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(be_o) == 1 || be_o == 4'h3 || be_o == 4'hC || be_o == 4'hF)); // R7

  AST_PRE_WB_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && pre_i) |=> (!wb_en_o || wb_val_o == addr_o)); // R4

  AST_POST_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !pre_i) |=> (!mem_req_o || (addr_o == $past(base_i) && wb_en_o))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!mem_req_o && !wb_en_o && !align_fault_o)); // R10

  AST_LD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && !mem_we_o) |-> ld_data_o == '0); // R9
endmodule

bind lsu_agu lsu_agu_chk #(.XLEN(XLEN)) i_lsu_agu_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .pre_i         (pre_i),
  .base_i        (base_i),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .addr_o        (addr_o),
  .be_o          (be_o),
  .wb_en_o       (wb_en_o),
  .wb_val_o      (wb_val_o),
  .align_fault_o (align_fault_o),
  .ld_data_o     (ld_data_o)
);

// File: tb/test_lsu_agu.sv
module test_lsu_agu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 0, is_load_i = 0, sub_i = 0, pre_i = 0, wb_i = 0, signed_i = 0;
  logic [31:0] base_i = 0, off_reg_i = 0, st_data_i = 0, rdata_i = 0;
  logic [1:0]  off_sel_i = 0, size_i = 0;
  logic [11:0] imm_i = 0;
  logic [4:0]  shamt_i = 0;
  logic        mem_req_o, mem_we_o, wb_en_o, align_fault_o;
  logic [31:0] addr_o, wdata_o, wb_val_o, ld_data_o;
  logic [3:0]  be_o;

  int total = 0, bad = 0, cycles = 0;

  // expected outputs
  logic        e_req = 0, e_we = 0, e_wb = 0, e_flt = 0;
  logic [31:0] e_addr = 0, e_wdata = 0, e_wbv = 0, e_ld = 0;
  logic [3:0]  e_be = 0;
  string       e_tag = "R1";

  always #4 clk_i = ~clk_i;

  lsu_agu i_lsu_agu (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string nm, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", e_tag, nm, act, exp);
    end
  endtask

  task automatic check_all();
    chk("mem_req", 32'(mem_req_o), 32'(e_req));
    chk("mem_we", 32'(mem_we_o), 32'(e_we));
    chk("addr", addr_o, e_addr);
    chk("be", 32'(be_o), 32'(e_be));
    chk("wdata", wdata_o, e_wdata);
    chk("wb_en", 32'(wb_en_o), 32'(e_wb));
    chk("wb_val", wb_val_o, e_wbv);
    chk("fault", 32'(align_fault_o), 32'(e_flt));
    chk("ld_data", ld_data_o, e_ld);
  endtask

  // one request (or idle) per cycle; checks previous result first
  task automatic op(input string tag, input bit rq, input bit ld, input logic [31:0] base,
                    input int sel, input logic [11:0] imm, input logic [31:0] oreg,
                    input int sh, input bit sb, input bit pr, input bit wb, input int sz,
                    input bit sg, input logic [31:0] sd, input logic [31:0] rd);
    longint unsigned ofs;
    logic [31:0] ea, acc, v;
    bit mis, go;
    @(negedge clk_i);
    check_all();
    req_i = rq; is_load_i = ld; base_i = base; off_sel_i = 2'(sel); imm_i = imm;
    off_reg_i = oreg; shamt_i = 5'(sh); sub_i = sb; pre_i = pr; wb_i = wb;
    size_i = 2'(sz); signed_i = sg; st_data_i = sd; rdata_i = rd;
    e_tag = tag;
    ofs = (sel == 0) ? 0 : (sel == 1) ? longint'(imm) : ((longint'(oreg) << sh) & 64'hFFFF_FFFF);
    ea  = sb ? base - 32'(ofs) : base + 32'(ofs);
    acc = pr ? ea : base;
    mis = (sz == 1 && acc[0]) || (sz >= 2 && acc[1:0] != 0);
    go  = rq && !mis;
    e_req = go; e_we = go && !ld; e_flt = rq && mis;
    e_wb = go && (!pr || wb);
    if (rq) begin e_addr = acc; e_wbv = ea; end
    if (!go) e_be = 0;
    else if (sz == 0) e_be = 4'b1 << acc[1:0];
    else if (sz == 1) e_be = acc[1] ? 4'hC : 4'h3;
    else e_be = 4'hF;
    if (!go || ld) e_wdata = 0;
    else if (sz == 0) e_wdata = {4{sd[7:0]}};
    else if (sz == 1) e_wdata = {2{sd[15:0]}};
    else e_wdata = sd;
    if (!go || !ld) e_ld = 0;
    else if (sz == 0) begin
      v = (rd >> (8 * acc[1:0])) & 32'hFF;
      e_ld = (sg && v[7]) ? (v | 32'hFFFF_FF00) : v;
    end else if (sz == 1) begin
      v = (rd >> (16 * acc[1])) & 32'hFFFF;
      e_ld = (sg && v[15]) ? (v | 32'hFFFF_0000) : v;
    end else e_ld = rd;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    check_all();                         // R1 during reset
    rst_ni = 1'b1;
    // R1 first edge after reset, idle
    op("R10", 0,0,0, 0,0,0, 0,0,0,0,0, 0,0,0);
    // R2 R4 immediate pre, no writeback, word load
    op("R4", 1,1,32'h1000, 1,12'hFFC,0, 0,0,1,0,2, 0,0,32'hDEAD_BEEF);
    // R2 R3 R4 register shifted, subtract, writeback, word store
    op("R3", 1,0,32'h2000, 2,0,32'h4, 4,1,1,1,2, 0,32'h1234_5678,0);
    // R3 subtract wraps below zero
    op("R3", 1,1,32'h0000_0004, 1,12'h8,0, 0,1,1,1,2, 0,0,32'hCAFE_0001);
    // R2 shift by 31
    op("R2", 1,1,32'h0, 3,0,32'h1, 31,0,1,1,0, 0,0,32'h0000_0000);
    // R2 zero offset
    op("R2", 1,1,32'h40, 0,12'hABC,32'hFF, 3,0,1,1,2, 0,0,32'h0BAD_F00D);
    // R5 R7 R8 post-index byte store at lane 2
    op("R8", 1,0,32'h302, 1,12'h10,0, 0,0,0,0,0, 0,32'hAABB_CC5A,0);
    // R9 signed byte load lane 3
    op("R9", 1,1,32'h103, 0,0,0, 0,0,1,0,0, 1,0,32'h80FF_FF7F);
    // R9 unsigned byte same data
    op("R9", 1,1,32'h103, 0,0,0, 0,0,1,0,0, 0,0,32'h80FF_FF7F);
    // R9 signed byte positive lane 0
    op("R9", 1,1,32'h100, 0,0,0, 0,0,1,0,0, 1,0,32'h80FF_FF7F);
    // R9 signed half high
    op("R9", 1,1,32'h102, 0,0,0, 0,0,1,0,1, 1,0,32'h8001_7FFF);
    // R9 unsigned half high
    op("R9", 1,1,32'h102, 0,0,0, 0,0,1,0,1, 0,0,32'h8001_7FFF);
    // R9 signed half low positive
    op("R9", 1,1,32'h100, 0,0,0, 0,0,0,0,1, 1,0,32'h8001_7FFF);
    // R7 R8 half store high
    op("R7", 1,0,32'h202, 0,0,0, 0,0,1,1,1, 0,32'h1111_BEEF,0);
    // R6 misaligned half (post-index uses base)
    op("R6", 1,1,32'h203, 1,12'h1,0, 0,0,0,0,1, 0,0,32'hFFFF_FFFF);
    // R6 misaligned word via pre offset
    op("R6", 1,0,32'h200, 1,12'h2,0, 0,0,1,1,2, 0,32'h5555_5555,0);
    // R6 reserved size code acts as word, aligned
    op("R6", 1,0,32'h208, 0,0,0, 0,0,1,0,3, 0,32'h0102_0304,0);
    // R10 idle after request: hold addr/wb_val
    op("R10", 0,1,32'h999, 1,12'h1,0, 0,0,1,1,0, 0,0,32'h1234_5678);
    op("R10", 0,0,0, 0,0,0, 0,0,0,0,0, 0,0,0);
    // random sweep
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rb;
      rb = $urandom;
      if (($urandom % 4) != 0) rb[1:0] = 2'b00;
      op("R7", ($urandom % 5) != 0, $urandom % 2, rb, $urandom % 4, 12'($urandom),
         ($urandom % 2) ? 32'($urandom % 4) : $urandom, $urandom % 32, $urandom % 2,
         $urandom % 2, $urandom % 2, $urandom % 4, $urandom % 2, $urandom, $urandom);
    end
    op("R10", 0,0,0, 0,0,0, 0,0,0,0,0, 0,0,0);
    @(negedge clk_i);
    check_all();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule